// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port

This block is a register-mapped general-purpose I/O port. Each pin has three pieces of state: a direction bit that makes the pin an output when set, a level bit, and an input bit that is sampled from the pad. When a pin is an output, its level bit sets the value driven on the pad. When a pin is an input, the same bit turns its pull-up on. One global input turns every pull-up off at once.

Software reaches the port through a small slave bus with an address, a write enable, write data and combinational read data. Full-byte writes replace the level or direction register. Dedicated set-bit and clear-bit addresses take a pin index in the low bits of the write data. These change exactly one pin and leave its neighbours untouched, with no read-modify-write sequence on the bus. Pad inputs pass through a synchronizer before they can be read.

Top module: `gpio_port`

## Requirements
- R1: After reset the level register and the direction register are both 0. So `padOe`, `padOut` and `padPullup` are all 0, and reads of address 0 and address 1 return 0.
- R2: A write to address 0 loads the whole level register from `wrData` on the next clock edge. Reads of address 0 return that register.
- R3: A write to address 1 loads the whole direction register on the next clock edge. Reads of address 1 return that register, and `padOe` equals it bit for bit (1 = output).
- R4: Reads of address 2 return `padIn` as it was two rising edges earlier. Writes to address 2 change neither the level register nor the direction register.
- R5: A write to address 3 sets bit `wrData[2:0]` of the level register, and a write to address 5 sets that bit of the direction register. All other bits stay unchanged.
- R6: A write to address 4 clears bit `wrData[2:0]` of the level register, and a write to address 6 clears that bit of the direction register. All other bits stay unchanged.
- R7: `padOut` equals the level register. `padPullup[n]` is 1 exactly when direction bit n is 0, level bit n is 1 and `pullupDisable` is 0.
- R8: Reads of addresses 3, 4, 5, 6 and 7 return 0.
- R9: While `pullupDisable` is 1, every bit of `padPullup` is 0, whatever the level and direction registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe for the current address |
| wrData | input | 8 | Write data, or the pin index in bits 2:0 |
| rdData | output | 8 | Combinational read data for `addr` |
| pullupDisable | input | 1 | Global pull-up kill |
| padIn | input | 8 | Raw pad input levels |
| padOe | output | 8 | Per-pin output enable |
| padOut | output | 8 | Per-pin driven level |
| padPullup | output | 8 | Per-pin pull-up enable |

## Verification
The bench builds the block with its defaults: eight pins and a two-stage synchronizer. With eight pins the three index bits of a set or clear write cover every position, so bit 0 and bit 7 are both exercised and no index can fall outside the port. With two stages, the bench can see the exact cycle in which a pad change becomes readable. A behavioural model is compared on every clock against all outputs and the read data. Random traffic then mixes all eight addresses with toggling of the pull-up disable.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 3;

  // register address map; set/clear strobes are write-only
  typedef enum logic [ADDR_W-1:0] {
    ADR_LEVEL     = 3'd0,
    ADR_DIR       = 3'd1,
    ADR_PINS      = 3'd2,
    ADR_LEVEL_SET = 3'd3,
    ADR_LEVEL_CLR = 3'd4,
    ADR_DIR_SET   = 3'd5,
    ADR_DIR_CLR   = 3'd6,
    ADR_SPARE     = 3'd7
  } regAddr_e;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_LEVEL = 2'd1,
    RD_DIR   = 2'd2,
    RD_PINS  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   loadLevel;
    logic   loadDir;
    logic   setLevel;
    logic   clrLevel;
    logic   setDir;
    logic   clrDir;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= '0;
    else       stageQ[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= '0;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobe
);

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_ZERO;
    unique case (addr)
      ADR_LEVEL: begin
        strobe.loadLevel = wrEn;
        strobe.rdSel     = RD_LEVEL;
      end
      ADR_DIR: begin
        strobe.loadDir = wrEn;
        strobe.rdSel   = RD_DIR;
      end
      ADR_PINS:      strobe.rdSel    = RD_PINS;
      ADR_LEVEL_SET: strobe.setLevel = wrEn;
      ADR_LEVEL_CLR: strobe.clrLevel = wrEn;
      ADR_DIR_SET:   strobe.setDir   = wrEn;
      ADR_DIR_CLR:   strobe.clrDir   = wrEn;
      default:       strobe.rdSel    = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/gpio_dpath.sv
module gpio_dpath
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic                pullupDisable,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padPullup
);

  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0] levelQ, levelD;
  logic [NUM_PINS-1:0] dirQ, dirD;
  logic [NUM_PINS-1:0] pinsSync;
  logic [NUM_PINS-1:0] bitMask;
  logic [IDX_W-1:0]    bitIdx;

  assign bitIdx  = wrData[IDX_W-1:0];
  assign bitMask = {{(NUM_PINS-1){1'b0}}, 1'b1} << bitIdx;

  always_comb begin
    levelD = levelQ;
    if (strobe.loadLevel)     levelD = wrData;
    else if (strobe.setLevel) levelD = levelQ | bitMask;
    else if (strobe.clrLevel) levelD = levelQ & ~bitMask;
  end

  always_comb begin
    dirD = dirQ;
    if (strobe.loadDir)     dirD = wrData;
    else if (strobe.setDir) dirD = dirQ | bitMask;
    else if (strobe.clrDir) dirD = dirQ & ~bitMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
      dirQ   <= '0;
    end else begin
      levelQ <= levelD;
      dirQ   <= dirD;
    end
  end

  gpio_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (padIn),
    .dout (pinsSync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign padOe[p]     = dirQ[p];
    assign padOut[p]    = levelQ[p];
    assign padPullup[p] = ~dirQ[p] & levelQ[p] & ~pullupDisable;
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_LEVEL: rdData = levelQ;
      RD_DIR:   rdData = dirQ;
      RD_PINS:  rdData = pinsSync;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic                pullupDisable,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padPullup
);

  strobe_t strobe;

  gpio_ctrl u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  gpio_dpath #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrData        (wrData),
    .pullupDisable (pullupDisable),
    .padIn         (padIn),
    .rdData        (rdData),
    .padOe         (padOe),
    .padOut        (padOut),
    .padPullup     (padPullup)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   addr,
  input logic                wrEn,
  input logic [NUM_PINS-1:0] wrData,
  input logic [NUM_PINS-1:0] rdData,
  input logic                pullupDisable,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padPullup
);

  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0] oneHot;
  assign oneHot = {{(NUM_PINS-1){1'b0}}, 1'b1} << wrData[IDX_W-1:0];

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && padOut == '0 && padPullup == '0)); // R1

  AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_LEVEL) |=> padOut == $past(wrData)); // R2

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_DIR) |=> padOe == $past(wrData)); // R3

  AST_PINS_READONLY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_PINS) |=> ($stable(padOe) && $stable(padOut))); // R4

  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_LEVEL_SET) |=> padOut == ($past(padOut) | $past(oneHot))); // R5

  AST_DIR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_DIR_SET) |=> padOe == ($past(padOe) | $past(oneHot))); // R5

  AST_LEVEL_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_LEVEL_CLR) |=> padOut == ($past(padOut) & ~$past(oneHot))); // R6

  AST_DIR_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_DIR_CLR) |=> padOe == ($past(padOe) & ~$past(oneHot))); // R6

  AST_PULLUP_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (padPullup & padOe) == '0); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr > ADR_PINS) |-> rdData == '0); // R8

  AST_PUD_KILLS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    pullupDisable |-> padPullup == '0); // R9

endmodule

bind gpio_port gpio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .addr          (addr),
  .wrEn          (wrEn),
  .wrData        (wrData),
  .rdData        (rdData),
  .pullupDisable (pullupDisable),
  .padOe         (padOe),
  .padOut        (padOut),
  .padPullup     (padPullup)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [2:0]       addr = '0;
  logic             wrEn = 1'b0;
  logic [NPINS-1:0] wrData = '0;
  logic             pullupDisable = 1'b0;
  logic [NPINS-1:0] padIn = '0;
  logic [NPINS-1:0] rdData, padOe, padOut, padPullup;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [NPINS-1:0] refLevel = '0;
  logic [NPINS-1:0] refDir = '0;
  logic [NPINS-1:0] pinQueue [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .addr          (addr),
    .wrEn          (wrEn),
    .wrData        (wrData),
    .rdData        (rdData),
    .pullupDisable (pullupDisable),
    .padIn         (padIn),
    .padOe         (padOe),
    .padOut        (padOut),
    .padPullup     (padPullup)
  );

  task automatic expect8(string req, string what, logic [NPINS-1:0] act, logic [NPINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model, updated on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      refLevel = '0;
      refDir   = '0;
      pinQueue = '{8'h00, 8'h00};
    end else begin
      pinQueue.push_back(padIn);
      void'(pinQueue.pop_front());
      if (wrEn) begin
        case (int'(addr))
          0: refLevel = wrData;
          1: refDir   = wrData;
          3: refLevel = refLevel | (8'h01 << wrData[2:0]);
          4: refLevel = refLevel & ~(8'h01 << wrData[2:0]);
          5: refDir   = refDir | (8'h01 << wrData[2:0]);
          6: refDir   = refDir & ~(8'h01 << wrData[2:0]);
          default: ;
        endcase
      end
    end
  end

  // compare a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rstN && !done) begin
      logic [NPINS-1:0] expRd;
      string rdReq;
      case (int'(addr))
        0: begin expRd = refLevel;    rdReq = "R2"; end
        1: begin expRd = refDir;      rdReq = "R3"; end
        2: begin expRd = pinQueue[0]; rdReq = "R4"; end
        default: begin expRd = '0;    rdReq = "R8"; end
      endcase
      expect8(rdReq, "rdData", rdData, expRd);
      expect8("R3", "padOe", padOe, refDir);
      expect8("R7", "padOut", padOut, refLevel);
      expect8(pullupDisable ? "R9" : "R7", "padPullup", padPullup,
              ~refDir & refLevel & {NPINS{~pullupDisable}});
    end
  end

  task automatic busWrite(input logic [2:0] a, input logic [NPINS-1:0] d);
    @(negedge clk);
    addr = a; wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readAt(input logic [2:0] a);
    @(negedge clk);
    addr = a;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect8("R1", "padOe in reset", padOe, 8'h00);
    expect8("R1", "padPullup in reset", padPullup, 8'h00);
    rstN = 1'b1;
    readAt(3'd0); expect8("R1", "level after reset", rdData, 8'h00);
    readAt(3'd1); expect8("R1", "dir after reset", rdData, 8'h00);
    expect8("R1", "padOut after reset", padOut, 8'h00);

    // R2 / R3: full-byte writes
    busWrite(3'd0, 8'hA5);
    readAt(3'd0); expect8("R2", "level readback", rdData, 8'hA5);
    busWrite(3'd1, 8'h0F);
    readAt(3'd1); expect8("R3", "dir readback", rdData, 8'h0F);
    expect8("R3", "padOe", padOe, 8'h0F);
    expect8("R7", "pullups on inputs", padPullup, 8'hA0);

    // R5 / R6: single-bit operations, including bit 0 and bit 7
    busWrite(3'd3, 8'h06);
    readAt(3'd0); expect8("R5", "level set bit6", rdData, 8'hE5);
    busWrite(3'd4, 8'hF8);
    readAt(3'd0); expect8("R6", "level clear bit0 (upper index bits ignored)", rdData, 8'hE4);
    busWrite(3'd5, 8'h07);
    readAt(3'd1); expect8("R5", "dir set bit7", rdData, 8'h8F);
    busWrite(3'd6, 8'h02);
    readAt(3'd1); expect8("R6", "dir clear bit2", rdData, 8'h8B);

    // R4: pins register is read-only and two edges late
    busWrite(3'd2, 8'hFF);
    readAt(3'd0); expect8("R4", "level after pins write", rdData, 8'hE4);
    readAt(3'd1); expect8("R4", "dir after pins write", rdData, 8'h8B);
    addr = 3'd2; padIn = 8'h3C;
    @(negedge clk); #1;
    expect8("R4", "pins after one edge", rdData, 8'h00);
    @(negedge clk); #1;
    expect8("R4", "pins after two edges", rdData, 8'h3C);

    // R8: unmapped reads
    for (int a = 3; a < 8; a++) begin
      readAt(3'(a)); expect8("R8", "unmapped read", rdData, 8'h00);
    end

    // R9: global disable
    busWrite(3'd1, 8'h00);
    busWrite(3'd0, 8'hFF);
    @(negedge clk); #1;
    expect8("R7", "all pullups on", padPullup, 8'hFF);
    pullupDisable = 1'b1; #1;
    expect8("R9", "all pullups off", padPullup, 8'h00);
    pullupDisable = 1'b0;

    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      addr = 3'($urandom_range(0, 7));
      wrEn = 1'($urandom_range(0, 1));
      wrData = 8'($urandom);
      padIn = 8'($urandom);
      pullupDisable = ($urandom_range(0, 7) == 0);
    end
    @(negedge clk);
    wrEn = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule